// File: doc/BRIEF.md
# Interrupt Summary Register

This block gathers interrupt requests from the sub-blocks of a line framer into one byte that a host processor reads first. Each bit names a sub-block that needs attention. The service routine reads the summary, branches to the flagged sub-block, and reads that sub-block's own status register. A combined active-high interrupt line is raised while any flagged bit is also enabled in a separate writable enable register.

The bits follow one of two clearing rules. Bits for the alarm, slip and data link sources stay set until the host reads that source's status register. Bits for one-second, recovered-clock-loss, signalling-bit and loopback-code events are cleared by reading the summary itself. The framer status bit tracks its request line. Reads are single-cycle strobes, and data returns on the next cycle. Any clear takes effect on that same cycle, so the byte returned is the value from before the clear.

Top module: `int_summary`

## Requirements
- R1: After reset (rst_ni low), the summary byte, the enable byte, rdata_o and irq_o are all 0.
- R2: A read (rd_i high for one cycle) of address 0x0B00 presents the summary byte on rdata_o in the next cycle. That byte is the value before any clear caused by the read. A read of 0x0B01 returns the enable byte. A read of any other address returns 0.
- R3: Reading 0x0B00 does not change bits 0 to 3 of the summary.
- R4: Bit 0 equals frm_req_i as sampled on the previous clock edge.
- R5: Bit 1 (alm_req_i), bit 2 (slip_req_i) and bit 3 (dl_req_i) latch when their request is high at a clock edge. Each clears on the edge at which its source register is read: address 0x0A02 for bit 1, 0x0A09 for bit 2 and 0x0A06 for bit 3. A read of any other of these addresses does not clear it.
- R6: Bit 4 (sec_evt_i), bit 5 (los_evt_i), bit 6 (sig_evt_i) and bit 7 (lbc_evt_i) latch on an event pulse and clear on the edge at which 0x0B00 is read.
- R7: If a bit's set input and its clearing read occur in the same cycle, the bit is 1 afterwards.
- R8: A write (wr_i high) to 0x0B01 loads wdata_i into the enable byte. irq_o is 1 exactly when some summary bit and the same enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host address |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| frm_req_i | input | 1 | Framer status request level |
| alm_req_i | input | 1 | Alarm and error request |
| slip_req_i | input | 1 | Slip buffer request |
| dl_req_i | input | 1 | Data link request |
| sec_evt_i | input | 1 | One-second event pulse |
| los_evt_i | input | 1 | Recovered clock loss event |
| sig_evt_i | input | 1 | Signalling-bit change event |
| lbc_evt_i | input | 1 | Loopback code event |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The checker watches every cycle for several properties. It checks that an event sets its sticky bit, and that a summary read clears that bit unless a new event coincides with the read. It checks that level bits survive a summary read, that returned data equals the pre-clear state, and that irq_o stays low while no enabled bit is set. The bench scenarios cover the rest. They show that each level bit clears only on the read of its own source address and not on a neighbour's. They also show that a read of an unmapped address returns zero, that the enable mask selects which bits drive irq_o, and that a back-to-back read sequence returns the expected byte stream.

// File: rtl/int_summary_pkg.sv
package int_summary_pkg;
  localparam int unsigned NBITS   = 8;
  localparam int unsigned B_FRM   = 0;
  localparam int unsigned B_ALM   = 1;
  localparam int unsigned B_SLIP  = 2;
  localparam int unsigned B_DL    = 3;
  localparam int unsigned B_SEC   = 4;
  localparam int unsigned B_LOS   = 5;
  localparam int unsigned B_SIG   = 6;
  localparam int unsigned B_LBC   = 7;
  typedef logic [NBITS-1:0] sum_t;
endpackage

// File: rtl/int_flag_cell.sv
module int_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates so a coincident event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/int_addr_dec.sv
module int_addr_dec
  import int_summary_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  SUM_ADDR = 16'h0B00,
  parameter logic [ADDR_W-1:0]  EN_ADDR  = 16'h0B01,
  parameter logic [ADDR_W-1:0]  SUB_BASE = 16'h0A00,
  parameter logic [ADDR_W-1:0]  ALM_OFS  = 16'h0002,
  parameter logic [ADDR_W-1:0]  SLIP_OFS = 16'h0009,
  parameter logic [ADDR_W-1:0]  DL_OFS   = 16'h0006
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              sum_rd_o,
  output logic              en_rd_o,
  output logic              en_wr_o,
  output sum_t              clr_o
);
  localparam logic [ADDR_W-1:0] ALM_A  = SUB_BASE + ALM_OFS;
  localparam logic [ADDR_W-1:0] SLIP_A = SUB_BASE + SLIP_OFS;
  localparam logic [ADDR_W-1:0] DL_A   = SUB_BASE + DL_OFS;

  always_comb begin
    sum_rd_o      = rd_i && (addr_i == SUM_ADDR);
    en_rd_o       = rd_i && (addr_i == EN_ADDR);
    en_wr_o       = wr_i && (addr_i == EN_ADDR);
    clr_o         = '0;
    clr_o[B_ALM]  = rd_i && (addr_i == ALM_A);
    clr_o[B_SLIP] = rd_i && (addr_i == SLIP_A);
    clr_o[B_DL]   = rd_i && (addr_i == DL_A);
    clr_o[B_SEC]  = sum_rd_o;
    clr_o[B_LOS]  = sum_rd_o;
    clr_o[B_SIG]  = sum_rd_o;
    clr_o[B_LBC]  = sum_rd_o;
  end
endmodule

// File: rtl/int_summary.sv
module int_summary
  import int_summary_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  SUM_ADDR = 16'h0B00,
  parameter logic [ADDR_W-1:0]  EN_ADDR  = 16'h0B01,
  parameter logic [ADDR_W-1:0]  SUB_BASE = 16'h0A00,
  parameter bit                 USE_RSV  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              frm_req_i,
  input  logic              alm_req_i,
  input  logic              slip_req_i,
  input  logic              dl_req_i,
  input  logic              sec_evt_i,
  input  logic              los_evt_i,
  input  logic              sig_evt_i,
  input  logic              lbc_evt_i,
  output logic              irq_o
);
  sum_t sum_q, en_q, set_v, clr_v;
  logic sum_rd, en_rd, en_wr;

  int_addr_dec #(
    .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR), .EN_ADDR(EN_ADDR), .SUB_BASE(SUB_BASE)
  ) u_dec (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .sum_rd_o(sum_rd), .en_rd_o(en_rd), .en_wr_o(en_wr), .clr_o(clr_v)
  );

  assign set_v = {lbc_evt_i, sig_evt_i, los_evt_i, sec_evt_i,
                  dl_req_i, slip_req_i, alm_req_i, frm_req_i};

  // bit 0 tracks its request level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q[B_FRM] <= 1'b0;
    else         sum_q[B_FRM] <= frm_req_i;
  end

  for (genvar i = 1; i < NBITS; i++) begin : g_flag
    if (i >= B_SIG && !USE_RSV) begin : g_off
      assign sum_q[i] = 1'b0;
    end else begin : g_on
      int_flag_cell u_cell (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .set_i(set_v[i]), .clr_i(clr_v[i]), .q_o(sum_q[i])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_wr) en_q <= wdata_i;
  end

  // registered read: captures pre-clear state on the strobe edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (rd_i)   rdata_o <= sum_rd ? sum_q : (en_rd ? en_q : '0);
  end

  assign irq_o = |(sum_q & en_q);
endmodule

module int_summary_chk #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SUM_ADDR = 16'h0B00
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              sec_evt_i,
  input logic              los_evt_i,
  input logic [7:0]        rdata_o,
  input logic              irq_o,
  input logic [7:0]        sum_q,
  input logic [7:0]        en_q
);
  logic sum_rd;
  assign sum_rd = rd_i && (addr_i == SUM_ADDR);

  a_r6_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_evt_i |=> sum_q[5]);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_rd && !sec_evt_i) |=> !sum_q[4]);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_rd && sec_evt_i) |=> sum_q[4]);
  a_r3_level_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_rd && sum_q[2]) |=> sum_q[2]);
  a_r2_pre_clear_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_rd |=> (rdata_o == $past(sum_q)));
  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sum_q & en_q) == 8'h00) |-> !irq_o);
endmodule

bind int_summary int_summary_chk #(.ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i),
  .sec_evt_i(sec_evt_i), .los_evt_i(los_evt_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .sum_q(sum_q), .en_q(en_q)
);

// File: tb/sim_int_summary.sv
module sim_int_summary;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        frm = 0, alm = 0, slip = 0, dl = 0, sec = 0, los = 0, sig = 0, lbc = 0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  int_summary u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .frm_req_i(frm), .alm_req_i(alm),
    .slip_req_i(slip), .dl_req_i(dl), .sec_evt_i(sec), .los_evt_i(los),
    .sig_evt_i(sig), .lbc_evt_i(lbc), .irq_o(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares read data the cycle after each strobe
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard", 8'h00, 8'hFF);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic host_rd(logic [15:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    addr = a; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic host_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk);
    {lbc, sig, los, sec, dl, slip, alm} = m[7:1];
    @(negedge clk);
    {lbc, sig, los, sec, dl, slip, alm} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rst_n = 1'b1;
    host_rd(16'h0B00, 8'h00, "R1 summary");
    host_rd(16'h0B01, 8'h00, "R1 enable");
    // R6 sticky events
    pulse(8'h10);
    host_rd(16'h0B00, 8'h10, "R6 sec latched");
    host_rd(16'h0B00, 8'h00, "R6 sec cleared");
    pulse(8'hE0);
    host_rd(16'h0B00, 8'hE0, "R6 los/sig/lbc latched");
    host_rd(16'h0B00, 8'h00, "R6 cleared");
    // R5 / R3 level bits
    pulse(8'h02);
    host_rd(16'h0B00, 8'h02, "R5 alm latched");
    host_rd(16'h0B00, 8'h02, "R3 alm kept");
    host_rd(16'h0A02, 8'h00, "R2 sub addr reads 0");
    host_rd(16'h0B00, 8'h00, "R5 alm cleared");
    pulse(8'h0C);
    host_rd(16'h0A06, 8'h00, "R5 dl src read");
    host_rd(16'h0B00, 8'h04, "R5 slip kept, dl cleared");
    host_rd(16'h0A09, 8'h00, "R5 slip src read");
    host_rd(16'h0B00, 8'h00, "R5 slip cleared");
    host_rd(16'h1234, 8'h00, "R2 unmapped");
    // R4 framer level
    @(negedge clk); frm = 1'b1;
    host_rd(16'h0B00, 8'h01, "R4 frm high");
    host_rd(16'h0B00, 8'h01, "R3 frm kept");
    @(negedge clk); frm = 1'b0;
    host_rd(16'h0B00, 8'h00, "R4 frm low");
    // R7 set wins over summary clear
    @(negedge clk);
    addr = 16'h0B00; rd = 1'b1; sec = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R7 pre-clear data");
    @(negedge clk);
    rd = 1'b0; sec = 1'b0;
    host_rd(16'h0B00, 8'h10, "R7 sec kept");
    // R7 set wins over source-read clear
    pulse(8'h02);
    @(negedge clk);
    addr = 16'h0A02; rd = 1'b1; alm = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R2 sub read");
    @(negedge clk);
    rd = 1'b0; alm = 1'b0;
    host_rd(16'h0B00, 8'h02, "R7 alm kept");
    host_rd(16'h0A02, 8'h00, "R5 alm src read");
    // R8 enable mask
    host_wr(16'h0B01, 8'h10);
    host_rd(16'h0B01, 8'h10, "R8 enable readback");
    check("R8 irq off, nothing set", {7'b0, irq}, 8'h00);
    pulse(8'h12);
    check("R8 irq on", {7'b0, irq}, 8'h01);
    host_wr(16'h0B01, 8'h20);
    @(negedge clk);
    check("R8 irq masked", {7'b0, irq}, 8'h00);
    host_wr(16'h0B01, 8'h02);
    @(negedge clk);
    check("R8 irq alm", {7'b0, irq}, 8'h01);
    host_rd(16'h0B00, 8'h12, "R8 summary");
    check("R8 irq alm still", {7'b0, irq}, 8'h01);
    host_rd(16'h0A02, 8'h00, "R5 alm src read");
    check("R8 irq cleared", {7'b0, irq}, 8'h00);
    repeat (3) @(negedge clk);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule